// File: doc/BRIEF.md
# Ternary Match Classifier with Priority

This block is a small ternary content-addressable rule table for packet classification. Each of its entries stores a pattern value, a care mask and a valid flag. A header key taken from a packet is compared against every entry in the same cycle. A bit whose care flag is cleared matches either key value, so each stored bit behaves as 0, 1 or don't-care. When several rules match, a priority encoder reports the single winner: the matching entry with the lowest index. The block returns that entry's index and a hit flag one clock after the lookup.

Rules are loaded through a write port, one entry per cycle, both before and during lookups. The key width is fixed by the hardware, so variable-length fields cannot be matched. The table cannot compare numbers arithmetically. Software must therefore split a numeric range, such as a port interval, into aligned power-of-two blocks and write each block as its own entry.

Top module: `tcam_classifier`

## Requirements
- R1: After reset, `res_valid`, `res_hit` and `res_idx` are 0 and every entry is invalid, so the first lookup misses.
- R2: An entry matches a key when it is valid and `((key ^ value) & mask)` is zero. A mask bit of 1 means the bit is compared, and a mask bit of 0 means don't-care.
- R3: Every entry is compared in the lookup cycle. The result appears on the clock edge after `lookup_en` is sampled high, with `res_valid` = 1.
- R4: When more than one entry matches, `res_idx` is the lowest matching index and `res_hit` is 1.
- R5: When no valid entry matches, `res_hit` is 0 and `res_idx` is 0 while `res_valid` is 1.
- R6: A write with `cfg_valid` = 0 removes the entry, and that entry never matches again until it is rewritten as valid.
- R7: A write and a lookup in the same cycle leave that lookup on the old table contents. The following lookup sees the new entry.
- R8: In the cycle after `lookup_en` is sampled low, `res_valid`, `res_hit` and `res_idx` are all 0.
- R9: A numeric range written as aligned power-of-two blocks (value = block base, mask = ~(size-1)) hits for every key inside the range and misses just outside it. Each key hits the block that contains it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one table entry this cycle |
| cfg_idx | input | 4 | Index of the entry to write |
| cfg_value | input | 32 | Pattern value to store |
| cfg_mask | input | 32 | Care mask (1 = compare the bit) |
| cfg_valid | input | 1 | Valid flag to store with the entry |
| lookup_en | input | 1 | Start a lookup with `lookup_key` |
| lookup_key | input | 32 | Header key to classify |
| res_valid | output | 1 | A lookup result is present |
| res_hit | output | 1 | At least one valid entry matched |
| res_idx | output | 4 | Index of the winning entry, 0 on a miss |

## Verification
The bench writes rules that overlap, so that a priority encoder scanning from the wrong end reports the higher index. It also clears a rule, so that a design that ignores the valid flag keeps hitting the stale entry. It writes an entry and looks it up in the same cycle: a table that forwards the write to the compare shows the new winner one lookup too early. It also expands a port range into power-of-two blocks and probes both ends of the range and the keys just outside it. A mask applied with the wrong sense, or a block boundary off by one, shows there as a wrong hit or a wrong index.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
    parameter int TCAM_KEY_W   = 32;
    parameter int TCAM_ENTRIES = 16;
    localparam int TCAM_IDX_W  = $clog2(TCAM_ENTRIES);

    typedef struct packed {
        logic                  valid;
        logic [TCAM_KEY_W-1:0] value;
        logic [TCAM_KEY_W-1:0] mask;
    } rule_t;

    typedef struct packed {
        logic                  valid;
        logic                  hit;
        logic [TCAM_IDX_W-1:0] idx;
    } result_t;
endpackage

// File: rtl/tcam_entry.sv
module tcam_entry
    import tcam_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TCAM_KEY_W-1:0] wr_value,
    input  logic [TCAM_KEY_W-1:0] wr_mask,
    input  logic                  wr_valid,
    input  logic [TCAM_KEY_W-1:0] key,
    output logic                  match
);
    rule_t rule_d, rule_q;

    always_comb begin
        rule_d = rule_q;
        if (wr_en) begin
            rule_d.valid = wr_valid;
            rule_d.value = wr_value;
            rule_d.mask  = wr_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rule_q <= '0;
        end else begin
            rule_q <= rule_d;
        end
    end

    // Compare against the stored rule only, so a write this cycle is seen next cycle
    assign match = rule_q.valid && (((key ^ rule_q.value) & rule_q.mask) == '0);

    // R6: a removed rule never reports a match
    assert_invalid_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rule_q.valid |-> !match);

    // R7: a write only changes the stored rule at the following edge
    assert_write_next_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rule_q.valid == $past(wr_valid)) && (rule_q.value == $past(wr_value)));
endmodule

// File: rtl/tcam_prio.sv
module tcam_prio
    import tcam_pkg::*;
(
    input  logic [TCAM_ENTRIES-1:0] req,
    output logic                    any,
    output logic [TCAM_IDX_W-1:0]   win
);
    // Scan from the top down so the lowest set index is the last one written
    always_comb begin
        any = 1'b0;
        win = '0;
        for (int i = TCAM_ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                win = TCAM_IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tcam_classifier.sv
module tcam_classifier
    import tcam_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [TCAM_IDX_W-1:0] cfg_idx,
    input  logic [TCAM_KEY_W-1:0] cfg_value,
    input  logic [TCAM_KEY_W-1:0] cfg_mask,
    input  logic                  cfg_valid,
    input  logic                  lookup_en,
    input  logic [TCAM_KEY_W-1:0] lookup_key,
    output logic                  res_valid,
    output logic                  res_hit,
    output logic [TCAM_IDX_W-1:0] res_idx
);
    logic [TCAM_ENTRIES-1:0] match_vec;
    logic                    any_match;
    logic [TCAM_IDX_W-1:0]   win_idx;
    result_t                 res_d, res_q;

    for (genvar g = 0; g < TCAM_ENTRIES; g++) begin : g_entry
        logic sel;
        assign sel = cfg_we && (cfg_idx == TCAM_IDX_W'(g));
        tcam_entry u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (sel),
            .wr_value (cfg_value),
            .wr_mask  (cfg_mask),
            .wr_valid (cfg_valid),
            .key      (lookup_key),
            .match    (match_vec[g])
        );
    end

    tcam_prio u_prio (
        .req (match_vec),
        .any (any_match),
        .win (win_idx)
    );

    always_comb begin
        res_d = '0;
        if (lookup_en) begin
            res_d.valid = 1'b1;
            res_d.hit   = any_match;
            res_d.idx   = any_match ? win_idx : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_hit   = res_q.hit;
    assign res_idx   = res_q.idx;

    // R3: every lookup yields a result one cycle later
    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_en |=> res_valid);

    // R8: no lookup, empty result
    assert_idle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_en |=> !res_valid && !res_hit && (res_idx == '0));

    // R2: the reported entry did match in the lookup cycle
    assert_hit_is_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> ((($past(match_vec) >> res_idx) & TCAM_ENTRIES'(1)) != '0));

    // R4: no lower-indexed entry matched
    assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (($past(match_vec) & ((TCAM_ENTRIES'(1) << res_idx) - TCAM_ENTRIES'(1))) == '0));

    // R5: a miss means nothing matched and the index is zero
    assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (($past(match_vec) == '0) && (res_idx == '0)));
endmodule

// File: tb/tcam_classifier_test.sv
module tcam_classifier_test;
    import tcam_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  cfg_we = 1'b0;
    logic [TCAM_IDX_W-1:0] cfg_idx = '0;
    logic [TCAM_KEY_W-1:0] cfg_value = '0;
    logic [TCAM_KEY_W-1:0] cfg_mask = '0;
    logic                  cfg_valid = 1'b0;
    logic                  lookup_en = 1'b0;
    logic [TCAM_KEY_W-1:0] lookup_key = '0;
    logic                  res_valid;
    logic                  res_hit;
    logic [TCAM_IDX_W-1:0] res_idx;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // bench copy of the table, updated from the requirements
    logic [TCAM_KEY_W-1:0] m_val [TCAM_ENTRIES];
    logic [TCAM_KEY_W-1:0] m_msk [TCAM_ENTRIES];
    logic                  m_vld [TCAM_ENTRIES];

    always #2 clk = ~clk;

    tcam_classifier uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_value(cfg_value), .cfg_mask(cfg_mask), .cfg_valid(cfg_valid),
        .lookup_en(lookup_en), .lookup_key(lookup_key),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx)
    );

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            summary();
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] model_find(logic [TCAM_KEY_W-1:0] k);
        for (int i = 0; i < TCAM_ENTRIES; i++)
            if (m_vld[i] && (((k ^ m_val[i]) & m_msk[i]) == '0))
                return {1'b1, 4'(i)};
        return 5'd0;
    endfunction

    task automatic write_rule(int idx, logic [31:0] v, logic [31:0] m, logic vld);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = TCAM_IDX_W'(idx);
        cfg_value = v; cfg_mask = m; cfg_valid = vld;
        @(negedge clk);
        cfg_we = 1'b0;
        m_val[idx] = v; m_msk[idx] = m; m_vld[idx] = vld;
    endtask

    // one lookup, checked against the bench model and against an explicit value
    task automatic lookup(string req, logic [31:0] k, logic exp_hit, int exp_idx);
        logic [4:0] mdl;
        mdl = model_find(k);
        @(negedge clk);
        lookup_en = 1'b1; lookup_key = k;
        @(negedge clk);
        lookup_en = 1'b0;
        chk({req, " valid"}, 32'(res_valid), 32'd1);
        chk({req, " hit"},   32'(res_hit), 32'(exp_hit));
        chk({req, " idx"},   32'(res_idx), 32'(exp_idx));
        chk({req, " model"}, {27'd0, res_hit, res_idx}, {27'd0, mdl});
    endtask

    task automatic t_reset_r1();
        @(negedge clk);
        chk("R1 reset valid", 32'(res_valid), 0);
        chk("R1 reset hit",   32'(res_hit), 0);
        chk("R1 reset idx",   32'(res_idx), 0);
        lookup("R1 empty table", 32'h0000_0000, 1'b0, 0);
    endtask

    task automatic t_ternary_r2();
        write_rule(3, 32'hAB00_0000, 32'hFF00_0000, 1'b1);
        lookup("R2 dont-care low bits", 32'hABCD_1234, 1'b1, 3);
        lookup("R2 cared bit differs", 32'hAC00_0000, 1'b0, 0);
        write_rule(0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b1);
        lookup("R2 exact match", 32'hDEAD_BEEF, 1'b1, 0);
        lookup("R5 one bit off", 32'hDEAD_BEEE, 1'b0, 0);
    endtask

    task automatic t_priority_r4();
        write_rule(1, 32'hAB00_0000, 32'hFFFF_0000, 1'b1);
        lookup("R4 two matches lowest wins", 32'hAB00_5555, 1'b1, 1);
        lookup("R3 single match", 32'hABCD_0000, 1'b1, 3);
    endtask

    task automatic t_invalidate_r6();
        write_rule(1, 32'hAB00_0000, 32'hFFFF_0000, 1'b0);
        lookup("R6 removed rule skipped", 32'hAB00_5555, 1'b1, 3);
    endtask

    task automatic t_same_cycle_r7();
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'd0;
        cfg_value = 32'hAB00_5555; cfg_mask = 32'hFFFF_FFFF; cfg_valid = 1'b1;
        lookup_en = 1'b1; lookup_key = 32'hAB00_5555;
        @(negedge clk);
        cfg_we = 1'b0; lookup_en = 1'b0;
        chk("R7 same-cycle sees old hit", 32'(res_hit), 1);
        chk("R7 same-cycle sees old idx", 32'(res_idx), 3);
        m_val[0] = 32'hAB00_5555; m_msk[0] = 32'hFFFF_FFFF; m_vld[0] = 1'b1;
        lookup("R7 next lookup sees new", 32'hAB00_5555, 1'b1, 0);
    endtask

    task automatic t_idle_r8();
        lookup("R8 prior lookup", 32'hAB00_5555, 1'b1, 0);
        @(negedge clk);
        chk("R8 idle valid", 32'(res_valid), 0);
        chk("R8 idle hit",   32'(res_hit), 0);
        chk("R8 idle idx",   32'(res_idx), 0);
    endtask

    task automatic t_range_r9();
        int lo = 130;
        int hi = 202;
        int slot = 4;
        while (lo <= hi) begin
            int sz = 1;
            while (((lo % (sz * 2)) == 0) && (lo + sz * 2 - 1 <= hi)) sz = sz * 2;
            write_rule(slot, 32'(lo), ~(32'(sz) - 32'd1), 1'b1);
            slot++;
            lo = lo + sz;
        end
        chk("R9 block count", 32'(slot - 4), 32'd8);
        lookup("R9 below range", 32'd129, 1'b0, 0);
        lookup("R9 low end",     32'd130, 1'b1, 4);
        lookup("R9 second block", 32'd132, 1'b1, 5);
        lookup("R9 middle",      32'd165, 1'b1, 8);
        lookup("R9 near top",    32'd200, 1'b1, 10);
        lookup("R9 high end",    32'd202, 1'b1, 11);
        lookup("R9 above range", 32'd203, 1'b0, 0);
    endtask

    initial begin
        for (int i = 0; i < TCAM_ENTRIES; i++) begin
            m_val[i] = '0; m_msk[i] = '0; m_vld[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r1();
        t_ternary_r2();
        t_priority_r4();
        t_invalidate_r6();
        t_same_cycle_r7();
        t_idle_r8();
        t_range_r9();
        repeat (2) @(negedge clk);
        summary();
    end
endmodule